// File: doc/BRIEF.md
# Stream Port Performance Counter Unit

This unit watches the streaming I/O ports of one tile and offers a host a pool of two shared performance counters. The host claims one or both counters with a one-cycle command that names a measurement mode and the ports to watch. It gets back a small handle, reads the running or finished count through that handle, and releases the counters with a stop command. Every port strobe is a single-cycle pulse in the counter clock domain.

Four modes exist. Active-time counts the cycles from a port's running event to its idle event, so stalled cycles count too. Sample-count adds one per running event. Byte-target counts the cycles from a start event until the bytes moved reach a programmed total. Latency counts the cycles from the start event of one port to the start event of another. The byte-target and latency modes bind both counters together. A claim that finds too few free counters is refused and leaves the current allocations as they are.

Top module: `spc_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_data` is 0 and both counters are free.
- R2: A command with `cmd_valid` high is answered in the next cycle with `rsp_valid` high for one cycle. Modes are encoded as active-time 0, sample-count 1, byte-target 2 and latency 3, and ops as claim 0, read 1 and stop 2. Bit i of a handle selects counter i. A claim for mode 0 or 1 takes the lowest free counter and returns 2'b01 or 2'b10. A claim for mode 2 or 3 needs both counters and returns 2'b11. A claim clears the counters it takes.
- R3: A claim that needs more counters than are free answers `rsp_err`=1 with handle 2'b00, and every existing allocation stays readable and unchanged.
- R4: A stop with a valid handle frees its counters so that they can be claimed again. A read or stop whose handle is 2'b00, or does not match an allocation exactly, answers `rsp_err`=1 and `rsp_data`=0.
- R5: Active-time mode on port A counts the cycles from a running strobe, inclusive, to the next idle strobe, exclusive. Running strobes while armed, and strobes on other ports, are ignored.
- R6: Sample-count mode adds one for each running strobe on port A and can be read at any time while it keeps counting. The difference of two reads equals the strobes seen between them.
- R7: Byte-target mode counts the cycles from a start strobe on port A up to and including the cycle in which the bytes moved, `BEAT_BYTES` per transfer strobe and counted from the start cycle, equal the target exactly. If the total passes the target without equalling it, the count never stops.
- R8: Latency mode counts the cycles from a start strobe on port A, inclusive, to a start strobe on port B, exclusive. Start strobes on A while armed, and start strobes on B before arming, are ignored.
- R9: A counter saturates at 2^CNT_W-1 and never wraps.
- R10: Strobes in the claim cycle are ignored. A finished count stays constant and readable until its handle is stopped. A read returns the count of the cycles before the read cycle, from the counter with the lower index bit set in the handle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 claim, 1 read, 2 stop, 3 reserved (error) |
| cmd_mode | input | 2 | Measurement mode for a claim |
| cmd_port_a | input | $clog2(NUM_PORTS) | Watched port (input port in latency mode) |
| cmd_port_b | input | $clog2(NUM_PORTS) | Output port for latency mode |
| cmd_target | input | CNT_W | Byte total for byte-target mode |
| cmd_handle | input | 2 | Handle for read and stop |
| ev_start | input | NUM_PORTS | Stream start strobes per port |
| ev_run | input | NUM_PORTS | Stream running strobes per port |
| ev_idle | input | NUM_PORTS | Stream idle strobes per port |
| ev_xfer | input | NUM_PORTS | Transfer strobes, BEAT_BYTES each |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Refused claim or bad handle |
| rsp_handle | output | 2 | Granted or echoed handle |
| rsp_data | output | CNT_W | Count returned by a read |

## Verification
The assertions check on every cycle that counters never wrap and hold at saturation, that a refused claim leaves the allocation state untouched, that a granted claim owns its counters, that error responses carry zero data, that a finished measurement holds its count, and that arming only follows a qualifying strobe. Only the bench's scenarios can show the exact cycle counts each mode produces, with the inclusive and exclusive ends and the ignored strobes. The same holds for the lowest-free choice, the reuse of counters after stop, the never-ending count when the byte total overshoots, and the differencing of sample reads.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int NCNT = 2;

  typedef enum logic [1:0] {M_ACTIVE = 2'd0, M_SAMPLES = 2'd1, M_BYTES = 2'd2, M_LATENCY = 2'd3} mode_e;
  typedef enum logic [1:0] {OP_CLAIM = 2'd0, OP_READ = 2'd1, OP_STOP = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {PH_WAIT = 2'd0, PH_ARMED = 2'd1, PH_DONE = 2'd2} phase_e;

  function automatic logic mode_pair(input logic [1:0] m);
    return (m == M_BYTES) || (m == M_LATENCY);
  endfunction
endpackage

// File: rtl/spc_acc.sv
module spc_acc #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] amt,
  output logic [CW-1:0] val
);
  logic [CW:0] sum;
  assign sum = {1'b0, val} + {1'b0, amt};

  always_ff @(posedge clk) begin
    if (rst || clr) val <= '0;
    else if (inc)   val <= sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (val >= $past(val))); // R9
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (val == {CW{1'b1}} && !clr) |=> (val == {CW{1'b1}})); // R9
endmodule

// File: rtl/spc_track.sv
module spc_track import spc_pkg::*; #(
  parameter int NP   = 4,
  parameter int PW   = 2,
  parameter int CW   = 64,
  parameter int BEAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] pa,
  input  logic [PW-1:0] pb,
  input  logic [CW-1:0] target,
  input  logic [CW-1:0] pair_bytes,
  input  logic [NP-1:0] ev_start,
  input  logic [NP-1:0] ev_run,
  input  logic [NP-1:0] ev_idle,
  input  logic [NP-1:0] ev_xfer,
  output logic          cyc_inc,
  output logic          byte_inc,
  output logic          done
);
  phase_e phase;
  logic sa, sb, ra, ia, xa, waiting, armed, arm, fin;
  logic [CW:0] sum;

  assign sa = ev_start[pa];
  assign sb = ev_start[pb];
  assign ra = ev_run[pa];
  assign ia = ev_idle[pa];
  assign xa = ev_xfer[pa];
  assign waiting = (phase == PH_WAIT);
  assign armed   = (phase == PH_ARMED);
  assign sum = {1'b0, pair_bytes} + (CW+1)'(BEAT);
  assign done = (phase == PH_DONE);

  always_comb begin
    arm = 1'b0; fin = 1'b0; cyc_inc = 1'b0; byte_inc = 1'b0;
    if (active) begin
      case (mode_e'(mode))
        M_ACTIVE: begin
          if (waiting && ra) begin arm = 1'b1; cyc_inc = 1'b1; end
          else if (armed) begin
            if (ia) fin = 1'b1;
            else    cyc_inc = 1'b1;
          end
        end
        M_SAMPLES: cyc_inc = ra;
        M_BYTES: begin
          if ((waiting && sa) || armed) begin
            arm      = waiting;
            cyc_inc  = 1'b1;
            byte_inc = xa;
            fin      = xa && (sum == {1'b0, target});
          end
        end
        default: begin
          if (waiting && sa) begin arm = 1'b1; cyc_inc = 1'b1; end
          else if (armed) begin
            if (sb) fin = 1'b1;
            else    cyc_inc = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) phase <= PH_WAIT;
    else if (fin)       phase <= PH_DONE;
    else if (arm)       phase <= PH_ARMED;
  end

  AST_ARM_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    (active && waiting && !sa && !ra) |=> (phase == PH_WAIT)); // R5
endmodule

// File: rtl/spc_alloc.sv
module spc_alloc import spc_pkg::*; #(
  parameter int PW = 2,
  parameter int CW = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [1:0]           cmd_mode,
  input  logic [PW-1:0]        cmd_pa,
  input  logic [PW-1:0]        cmd_pb,
  input  logic [CW-1:0]        cmd_tgt,
  input  logic [1:0]           cmd_handle,
  input  logic [1:0][CW-1:0]   cnt_val,
  output logic [1:0]           alloc,
  output logic [1:0][1:0]      owner,
  output logic [1:0][1:0]      cfg_mode,
  output logic [1:0][PW-1:0]   cfg_pa,
  output logic [1:0][PW-1:0]   cfg_pb,
  output logic [1:0][CW-1:0]   cfg_tgt,
  output logic [1:0]           clr,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [1:0]           rsp_handle,
  output logic [CW-1:0]        rsp_data
);
  logic is_claim, is_read, is_stop, claim_ok, hval;
  logic [1:0] free, claim_h;
  logic [CW-1:0] rd_sel;

  assign is_claim = cmd_valid && (cmd_op == OP_CLAIM);
  assign is_read  = cmd_valid && (cmd_op == OP_READ);
  assign is_stop  = cmd_valid && (cmd_op == OP_STOP);
  assign free = ~alloc;

  always_comb begin
    if (mode_pair(cmd_mode)) begin
      claim_ok = &free;
      claim_h  = 2'b11;
    end else begin
      claim_ok = |free;
      claim_h  = free[0] ? 2'b01 : 2'b10;
    end
  end

  always_comb begin
    hval = (cmd_handle != 2'b00);
    for (int i = 0; i < NCNT; i++)
      if (cmd_handle[i] && !(alloc[i] && owner[i] == cmd_handle)) hval = 1'b0;
  end

  assign clr    = (is_claim && claim_ok) ? claim_h : 2'b00;
  assign rd_sel = cmd_handle[0] ? cnt_val[0] : cnt_val[1];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCNT; i++) begin
      if (rst) begin
        alloc[i] <= 1'b0; owner[i] <= 2'b00; cfg_mode[i] <= 2'b00;
        cfg_pa[i] <= '0; cfg_pb[i] <= '0; cfg_tgt[i] <= '0;
      end else if (clr[i]) begin
        alloc[i] <= 1'b1; owner[i] <= claim_h; cfg_mode[i] <= cmd_mode;
        cfg_pa[i] <= cmd_pa; cfg_pb[i] <= cmd_pb; cfg_tgt[i] <= cmd_tgt;
      end else if (is_stop && hval && cmd_handle[i]) begin
        alloc[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_handle <= 2'b00; rsp_data <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_data <= '0;
        if (is_claim) begin
          rsp_err    <= !claim_ok;
          rsp_handle <= claim_ok ? claim_h : 2'b00;
        end else if (is_read || is_stop) begin
          rsp_err    <= !hval;
          rsp_handle <= hval ? cmd_handle : 2'b00;
          if (is_read && hval) rsp_data <= rd_sel;
        end else begin
          rsp_err    <= 1'b1;
          rsp_handle <= 2'b00;
        end
      end
    end
  end

  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (is_claim && !claim_ok) |=> ($stable(alloc) && $stable(owner))); // R3
  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
    (is_claim && claim_ok) |=> ((alloc & $past(claim_h)) == $past(claim_h))); // R2
  AST_RSP_LATE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid)); // R2
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == '0 && rsp_handle == 2'b00)); // R4
endmodule

// File: rtl/spc_unit.sv
module spc_unit import spc_pkg::*; #(
  parameter int NUM_PORTS  = 4,
  parameter int CNT_W      = 64,
  parameter int BEAT_BYTES = 4,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [1:0]           cmd_mode,
  input  logic [PW-1:0]        cmd_port_a,
  input  logic [PW-1:0]        cmd_port_b,
  input  logic [CNT_W-1:0]     cmd_target,
  input  logic [1:0]           cmd_handle,
  input  logic [NUM_PORTS-1:0] ev_start,
  input  logic [NUM_PORTS-1:0] ev_run,
  input  logic [NUM_PORTS-1:0] ev_idle,
  input  logic [NUM_PORTS-1:0] ev_xfer,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [1:0]           rsp_handle,
  output logic [CNT_W-1:0]     rsp_data
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] BEAT = CNT_W'(BEAT_BYTES);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [1:0]             alloc, clr, prim, cyc, bi, done, inc;
  logic [1:0][1:0]        owner, cfg_mode;
  logic [1:0][PW-1:0]     cfg_pa, cfg_pb;
  logic [1:0][CNT_W-1:0]  cfg_tgt, cnt_val, amt;
  logic                   sec1;

  spc_alloc #(.PW(PW), .CW(CNT_W)) u_alloc (
    .clk, .rst, .cmd_valid, .cmd_op, .cmd_mode,
    .cmd_pa(cmd_port_a), .cmd_pb(cmd_port_b), .cmd_tgt(cmd_target), .cmd_handle,
    .cnt_val, .alloc, .owner, .cfg_mode, .cfg_pa, .cfg_pb, .cfg_tgt, .clr,
    .rsp_valid, .rsp_err, .rsp_handle, .rsp_data
  );

  assign prim[0] = alloc[0] && (owner[0] == 2'b01 || owner[0] == 2'b11);
  assign prim[1] = alloc[1] && (owner[1] == 2'b10);
  assign sec1    = alloc[1] && (owner[1] == 2'b11);

  assign inc[0] = cyc[0];
  assign amt[0] = ONE;
  assign inc[1] = prim[1] ? cyc[1] : (sec1 && (bi[0] || bi[1]));
  assign amt[1] = prim[1] ? ONE : BEAT;

  for (genvar g = 0; g < NCNT; g++) begin : g_slot
    spc_track #(.NP(NUM_PORTS), .PW(PW), .CW(CNT_W), .BEAT(BEAT_BYTES)) u_track (
      .clk, .rst, .active(prim[g]), .mode(cfg_mode[g]), .pa(cfg_pa[g]), .pb(cfg_pb[g]),
      .target(cfg_tgt[g]), .pair_bytes(g == 0 ? cnt_val[1] : ZERO),
      .ev_start, .ev_run, .ev_idle, .ev_xfer,
      .cyc_inc(cyc[g]), .byte_inc(bi[g]), .done(done[g])
    );
    spc_acc #(.CW(CNT_W)) u_acc (
      .clk, .rst, .clr(clr[g]), .inc(inc[g]), .amt(amt[g]), .val(cnt_val[g])
    );
  end

  AST_HOLD_END0: assert property (@(posedge clk) disable iff (rst)
    (prim[0] && done[0] && !clr[0]) |=> $stable(cnt_val[0])); // R10
  AST_HOLD_END1: assert property (@(posedge clk) disable iff (rst)
    (((prim[1] && done[1]) || (sec1 && done[0])) && !clr[1]) |=> $stable(cnt_val[1])); // R10
endmodule

// File: tb/spc_unit_test.sv
module spc_unit_test;
  localparam int NP = 4, CW = 8, BEAT = 4, PW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cmd_valid;
  logic [1:0] cmd_op, cmd_mode, cmd_handle;
  logic [PW-1:0] cmd_port_a, cmd_port_b;
  logic [CW-1:0] cmd_target;
  logic [NP-1:0] ev_start, ev_run, ev_idle, ev_xfer;
  logic rsp_valid, rsp_err;
  logic [1:0] rsp_handle;
  logic [CW-1:0] rsp_data;

  spc_unit #(.NUM_PORTS(NP), .CNT_W(CW), .BEAT_BYTES(BEAT)) uut (
    .clk, .rst, .cmd_valid, .cmd_op, .cmd_mode, .cmd_port_a, .cmd_port_b,
    .cmd_target, .cmd_handle, .ev_start, .ev_run, .ev_idle, .ev_xfer,
    .rsp_valid, .rsp_err, .rsp_handle, .rsp_data
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [1:0] h;
  logic [CW-1:0] v1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [1:0] mode, input int pa, input int pb,
                        input int tgt, input logic [1:0] hd);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = mode;
    cmd_port_a = PW'(pa); cmd_port_b = PW'(pb); cmd_target = CW'(tgt); cmd_handle = hd;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic claim(input logic [1:0] mode, input int pa, input int pb, input int tgt);
    do_cmd(2'd0, mode, pa, pb, tgt, 2'b00);
    h = rsp_handle;
  endtask

  task automatic rd(input logic [1:0] hd);
    do_cmd(2'd1, 2'd0, 0, 0, 0, hd);
  endtask

  task automatic stp(input logic [1:0] hd);
    do_cmd(2'd2, 2'd0, 0, 0, 0, hd);
  endtask

  // kind: 0 start, 1 run, 2 idle, 3 xfer
  task automatic pulse(input int kind, input int port);
    case (kind)
      0: ev_start[port] = 1'b1;
      1: ev_run[port]   = 1'b1;
      2: ev_idle[port]  = 1'b1;
      default: ev_xfer[port] = 1'b1;
    endcase
    tick();
    ev_start = '0; ev_run = '0; ev_idle = '0; ev_xfer = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 0; cmd_mode = 0; cmd_handle = 0;
    cmd_port_a = 0; cmd_port_b = 0; cmd_target = 0;
    ev_start = '0; ev_run = '0; ev_idle = '0; ev_xfer = '0;
    idle_n(3);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 rsp_data after reset", rsp_data, 0);
    rst = 1'b0;
    tick();

    // allocation and handles
    claim(2'd0, 0, 0, 0);
    check("R1 first claim handle", h, 2'b01);
    check("R2 rsp_valid one cycle", rsp_valid, 1);
    tick();
    check("R2 rsp_valid drops", rsp_valid, 0);
    claim(2'd1, 1, 0, 0);
    check("R2 second single handle", h, 2'b10);
    claim(2'd0, 2, 0, 0);
    check("R3 no free counter err", rsp_err, 1);
    check("R3 no free counter handle", rsp_handle, 2'b00);
    rd(2'b01);
    check("R3 allocation kept", rsp_err, 0);
    stp(2'b01);
    check("R4 stop ok", rsp_err, 0);
    rd(2'b01);
    check("R4 read freed err", rsp_err, 1);
    check("R4 read freed data", rsp_data, 0);
    claim(2'd2, 0, 0, 12);
    check("R3 pair with one free", rsp_err, 1);
    rd(2'b10);
    check("R3 single kept after pair fail", rsp_err, 0);
    stp(2'b10);
    stp(2'b10);
    check("R4 double stop err", rsp_err, 1);
    rd(2'b00);
    check("R4 null handle err", rsp_err, 1);
    claim(2'd3, 0, 3, 0);
    check("R2 pair handle", h, 2'b11);
    rd(2'b01);
    check("R4 mismatched handle err", rsp_err, 1);
    stp(2'b11);
    check("R4 pair stop", rsp_err, 0);

    // active-time sweep
    for (int k = 0; k < 6; k++) begin
      int p = k % NP;
      claim(2'd0, p, 0, 0);
      check("R2 active claim handle", h, 2'b01);
      tick();
      pulse(1, p);
      for (int j = 0; j < k; j++) begin
        if (j == 0) pulse(2, (p + 1) % NP);
        else if (j == 1) pulse(1, p);
        else tick();
      end
      pulse(2, p);
      idle_n(3);
      rd(h);
      check($sformatf("R5 active k=%0d", k), rsp_data, k + 1);
      pulse(1, p); pulse(2, p);
      rd(h);
      check("R10 active held", rsp_data, k + 1);
      stp(h);
    end

    // sample-count, claim-cycle strobe ignored
    ev_run[2] = 1'b1;
    claim(2'd1, 2, 0, 0);
    ev_run = '0;
    rd(h);
    check("R10 claim cycle strobe ignored", rsp_data, 0);
    for (int n = 0; n < 3; n++) begin pulse(1, 2); tick(); pulse(1, 1); end
    rd(h);
    check("R6 samples first read", rsp_data, 3);
    v1 = rsp_data;
    pulse(1, 2); pulse(1, 2);
    rd(h);
    check("R6 samples difference", rsp_data - v1, 2);
    stp(h);

    // byte-target sweep
    for (int g = 0; g < 4; g++) begin
      claim(2'd2, g, 0, 12);
      check("R2 bytes handle", h, 2'b11);
      tick();
      pulse(0, g);
      idle_n(g);
      pulse(3, (g + 1) % NP);
      pulse(3, g); pulse(3, g); pulse(3, g);
      idle_n(4);
      rd(h);
      check($sformatf("R7 bytes g=%0d", g), rsp_data, g + 5);
      pulse(3, g);
      rd(h);
      check("R10 bytes held", rsp_data, g + 5);
      stp(h);
    end
    claim(2'd2, 1, 0, 8);
    ev_start[1] = 1'b1; ev_xfer[1] = 1'b1; tick(); ev_start = '0; ev_xfer = '0;
    pulse(3, 1);
    idle_n(2);
    rd(h);
    check("R7 xfer in start cycle", rsp_data, 2);
    stp(h);
    claim(2'd2, 0, 0, 10);
    pulse(0, 0);
    for (int i = 0; i < 5; i++) pulse(3, 0);
    rd(h);
    v1 = rsp_data;
    idle_n(5);
    rd(h);
    check("R7 overshoot keeps counting", rsp_data - v1, 6);
    stp(h);

    // latency sweep
    for (int k = 0; k < 4; k++) begin
      claim(2'd3, 0, 3, 0);
      pulse(0, 3);
      pulse(0, 0);
      for (int j = 0; j < k; j++) begin
        if (j == 0) pulse(0, 0);
        else tick();
      end
      pulse(0, 3);
      idle_n(2);
      rd(h);
      check($sformatf("R8 latency k=%0d", k), rsp_data, k + 1);
      stp(h);
    end

    // saturation
    claim(2'd0, 0, 0, 0);
    pulse(1, 0);
    idle_n(300);
    rd(h);
    check("R9 saturates", rsp_data, 255);
    pulse(2, 0);
    rd(h);
    check("R9 saturated held", rsp_data, 255);
    stp(h);
    claim(2'd0, 0, 0, 0);
    rd(h);
    check("R2 claim clears counter", rsp_data, 0);
    stp(h);

    finish_run();
  end
endmodule